// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block guards physical memory against disallowed accesses. It holds a set of protection regions. Each region has an 8-bit configuration byte and a 32-bit address register. Software reaches both through a 32-bit CSR-style read/write port. Every access presented to the block carries a 34-bit byte address, a kind (instruction fetch, data load or data store) and a privilege level (machine or user). One cycle later the block reports either allow or fault. A fault comes with the access-fault cause code for that kind of access.

Each region picks one of four address-matching modes at run time:
- disabled;
- top-of-range, which uses the previous region's address as its lower bound;
- a naturally aligned 4-byte word;
- a naturally aligned power-of-two window, whose size is encoded by the trailing ones of the address register.

The lowest-numbered region that matches decides the outcome. A locked region cannot be rewritten until reset, and its permissions apply even to machine-mode accesses. A build parameter sets how many regions are addressable. A second parameter sets how many of them are backed by real storage; the others read as zero.

Top module: `pmp_unit`

## Requirements
- R1: Configuration byte of region n is read and written in config CSR 0x3A0 + n/4 at bits 8*(n%4)+7 : 8*(n%4). Bit 0 = read, bit 1 = write, bit 2 = execute, bits 4:3 = mode, bit 7 = lock. The address register of region n is CSR 0x3B0 + n and holds byte address bits 33:2. Read data is valid combinationally, in the same cycle as the address.
- R2: Regions at or above the implemented count (8 of 16 by default) read as zero, and writes to them have no effect.
- R3: Once a region's lock bit is set, writes to its configuration byte and to its address register are ignored until reset. Other bytes of the same config CSR still update.
- R4: Mode 0 (off) never matches, whatever permissions the byte holds.
- R5: Mode 1 (top of range) matches byte addresses A with {prev,2'b00} <= A < {own,2'b00}. Here prev is the address register of the region below, or 0 for region 0.
- R6: Mode 2 matches the 4 bytes starting at {own,2'b00}.
- R7: Mode 3 matches from x&(x+1) to x|(x+1) inclusive, where x = {own,2'b11} in 34 bits.
- R8: When several regions match, only the lowest-numbered one decides.
- R9: In machine mode (acc_priv=1), an access is allowed if no region matches or if the deciding region is unlocked. A locked deciding region enforces its permissions.
- R10: In user mode (acc_priv=0), an access with no matching region is denied. Otherwise the deciding region's read, write or execute bit grants it.
- R11: The result appears on chk_valid/chk_fault/chk_cause on the clock edge after acc_valid is sampled. The fault cause is 1 for a fetch (acc_type=0), 5 for a load (acc_type=1) and 7 for a store (acc_type=2). The cause is 0 when the access is allowed or chk_valid is low.
- R12: After reset, all configuration and address registers read zero and chk_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data, combinational |
| acc_valid | input | 1 | Access check request |
| acc_addr | input | 34 | Access byte address |
| acc_type | input | 2 | 0 fetch, 1 load, 2 store |
| acc_priv | input | 1 | 1 machine, 0 user |
| chk_valid | output | 1 | Result valid |
| chk_fault | output | 1 | Access denied |
| chk_cause | output | 4 | Fault cause code, 0 when allowed |

## Verification
CSR writes take effect at the clock edge on which csr_we is sampled. CSR read data depends only on the address, so the bench reads it a little after setting the address, in the same low clock phase. An access driven at a falling edge is registered at the next rising edge. Its verdict is therefore checked at the following falling edge, exactly one cycle later. The lock checks write first and then read back through the same CSR port before any other stimulus.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] rsvd;
    amode_e     mode;
    logic       x;
    logic       w;
    logic       r;
  } rcfg_t;

  localparam logic [11:0] CSR_CFG_BASE  = 12'h3A0;
  localparam logic [11:0] CSR_ADDR_BASE = 12'h3B0;

  localparam logic [3:0] CAUSE_FETCH = 4'd1;
  localparam logic [3:0] CAUSE_LOAD  = 4'd5;
  localparam logic [3:0] CAUSE_STORE = 4'd7;

endpackage

// File: rtl/pmp_csr_bank.sv
module pmp_csr_bank
  import pmp_pkg::*;
#(
  parameter int NREG = 16,
  parameter int NIMP = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        csr_we,
  input  logic [11:0] csr_addr,
  input  logic [31:0] csr_wdata,
  output logic [31:0] csr_rdata,
  output rcfg_t       cfg_o  [NREG],
  output logic [31:0] addr_o [NREG]
);
  localparam int NCFG = NREG / 4;

  logic [11:0] off_cfg, off_addr;
  logic        hit_cfg, hit_addr;

  assign off_cfg  = csr_addr - CSR_CFG_BASE;
  assign off_addr = csr_addr - CSR_ADDR_BASE;
  assign hit_cfg  = off_cfg  < 12'(NCFG);
  assign hit_addr = off_addr < 12'(NREG);

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    if (i < NIMP) begin : g_real
      rcfg_t       cfg_q, cfg_d;
      logic [31:0] adr_q, adr_d;
      logic        cfg_en, adr_en;

      always_comb begin
        cfg_en = csr_we && hit_cfg && (off_cfg == 12'(i / 4)) && !cfg_q.lock;
        adr_en = csr_we && hit_addr && (off_addr == 12'(i)) && !cfg_q.lock;
        cfg_d  = cfg_q;
        adr_d  = adr_q;
        if (cfg_en) cfg_d = rcfg_t'(csr_wdata[8*(i%4) +: 8]);
        if (adr_en) adr_d = csr_wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cfg_q <= '0;
          adr_q <= '0;
        end else begin
          if (cfg_en) cfg_q <= cfg_d;
          if (adr_en) adr_q <= adr_d;
        end
      end

      assign cfg_o[i]  = cfg_q;
      assign addr_o[i] = adr_q;

      AST_LOCK_FREEZES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock |=> $stable(cfg_q)); // R3
      AST_LOCK_FREEZES_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.lock |=> $stable(adr_q)); // R3
    end else begin : g_zero
      assign cfg_o[i]  = '0;
      assign addr_o[i] = '0;
    end
  end

  always_comb begin
    csr_rdata = '0;
    for (int k = 0; k < NCFG; k++) begin
      if (hit_cfg && off_cfg == 12'(k)) begin
        for (int j = 0; j < 4; j++) csr_rdata[8*j +: 8] = cfg_o[4*k+j];
      end
    end
    for (int n = 0; n < NREG; n++) begin
      if (hit_addr && off_addr == 12'(n)) csr_rdata = addr_o[n];
    end
  end

endmodule

// File: rtl/pmp_match.sv
module pmp_match
  import pmp_pkg::*;
#(
  parameter int PA_W = 34
) (
  input  amode_e            mode,
  input  logic [PA_W-3:0]   reg_own,
  input  logic [PA_W-3:0]   reg_prev,
  input  logic [PA_W-1:0]   acc_addr,
  output logic              hit
);
  logic [PA_W-1:0] nap_x, nap_lo, nap_hi, tor_lo, tor_hi;

  always_comb begin
    nap_x  = {reg_own, 2'b11};
    nap_lo = nap_x & (nap_x + 1'b1);
    nap_hi = nap_x | (nap_x + 1'b1);
    tor_lo = {reg_prev, 2'b00};
    tor_hi = {reg_own, 2'b00};
    unique case (mode)
      MODE_TOR:   hit = (acc_addr >= tor_lo) && (acc_addr < tor_hi);
      MODE_NA4:   hit = (acc_addr[PA_W-1:2] == reg_own);
      MODE_NAPOT: hit = (acc_addr >= nap_lo) && (acc_addr <= nap_hi);
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/pmp_resolve.sv
module pmp_resolve
  import pmp_pkg::*;
#(
  parameter int NREG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NREG-1:0] hit,
  input  rcfg_t           cfg [NREG],
  input  logic [1:0]      acc_type,
  input  logic            acc_priv,
  output logic            deny
);
  logic [NREG-1:0] win;
  logic            any, lk, ok;

  always_comb begin
    win = '0;
    any = 1'b0;
    lk  = 1'b0;
    ok  = 1'b0;
    for (int i = 0; i < NREG; i++) begin
      if (hit[i] && !any) begin
        win[i] = 1'b1;
        any    = 1'b1;
        lk     = cfg[i].lock;
        unique case (acc_type)
          ACC_FETCH: ok = cfg[i].x;
          ACC_LOAD:  ok = cfg[i].r;
          ACC_STORE: ok = cfg[i].w;
          default:   ok = 1'b0;
        endcase
      end
    end
    if (!any)                deny = !acc_priv;
    else if (acc_priv && !lk) deny = 1'b0;
    else                     deny = !ok;
  end

  AST_SINGLE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |-> ($onehot0(win) && (win != '0))); // R8

endmodule

// File: rtl/pmp_unit.sv
module pmp_unit
  import pmp_pkg::*;
#(
  parameter int NREG = 16,
  parameter int NIMP = 8,
  parameter int PA_W = 34
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [31:0]     csr_wdata,
  output logic [31:0]     csr_rdata,
  input  logic            acc_valid,
  input  logic [PA_W-1:0] acc_addr,
  input  logic [1:0]      acc_type,
  input  logic            acc_priv,
  output logic            chk_valid,
  output logic            chk_fault,
  output logic [3:0]      chk_cause
);
  logic [1:0] rst_sync;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok = rst_sync[1];

  rcfg_t           cfg  [NREG];
  logic [31:0]     areg [NREG];
  logic [NREG-1:0] hit;
  logic            deny;

  pmp_csr_bank #(.NREG(NREG), .NIMP(NIMP)) u_bank (
    .clk(clk), .rst_n(rst_ok), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .cfg_o(cfg), .addr_o(areg)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_m
    logic [PA_W-3:0] prev;
    if (i == 0) begin : g_first
      assign prev = '0;
    end else begin : g_next
      assign prev = areg[i-1][PA_W-3:0];
    end
    pmp_match #(.PA_W(PA_W)) u_m (
      .mode(cfg[i].mode), .reg_own(areg[i][PA_W-3:0]), .reg_prev(prev),
      .acc_addr(acc_addr), .hit(hit[i])
    );
  end

  pmp_resolve #(.NREG(NREG)) u_res (
    .clk(clk), .rst_n(rst_ok), .hit(hit), .cfg(cfg),
    .acc_type(acc_type), .acc_priv(acc_priv), .deny(deny)
  );

  logic       vld_d, flt_d;
  logic [3:0] cause_d;

  always_comb begin
    vld_d   = acc_valid;
    flt_d   = acc_valid && deny;
    cause_d = 4'd0;
    if (flt_d) begin
      unique case (acc_type)
        ACC_FETCH: cause_d = CAUSE_FETCH;
        ACC_LOAD:  cause_d = CAUSE_LOAD;
        default:   cause_d = CAUSE_STORE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      chk_valid <= 1'b0;
      chk_fault <= 1'b0;
      chk_cause <= 4'd0;
    end else begin
      chk_valid <= vld_d;
      chk_fault <= flt_d;
      chk_cause <= cause_d;
    end
  end

  AST_RESULT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_ok)
    acc_valid |=> chk_valid); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    !chk_valid |-> (!chk_fault && chk_cause == 4'd0)); // R11
  AST_CAUSE_BY_KIND: assert property (@(posedge clk) disable iff (!rst_ok)
    (acc_valid && acc_type == ACC_LOAD) |=> (!chk_fault || chk_cause == 4'd5)); // R11
  AST_ALLOW_NO_CAUSE: assert property (@(posedge clk) disable iff (!rst_ok)
    (chk_valid && !chk_fault) |-> chk_cause == 4'd0); // R11

endmodule

// File: tb/sim_pmp_unit.sv
module sim_pmp_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_we;
  logic [11:0] csr_addr;
  logic [31:0] csr_wdata;
  logic [31:0] csr_rdata;
  logic        acc_valid;
  logic [33:0] acc_addr;
  logic [1:0]  acc_type;
  logic        acc_priv;
  logic        chk_valid, chk_fault;
  logic [3:0]  chk_cause;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pmp_unit u0 (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_type(acc_type), .acc_priv(acc_priv),
    .chk_valid(chk_valid), .chk_fault(chk_fault), .chk_cause(chk_cause)
  );

  task automatic expect32(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic csr_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_chk(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    csr_addr = a;
    #1;
    expect32(req, csr_rdata, exp);
  endtask

  // kind: 0 fetch, 1 load, 2 store; priv 1 machine; exp_cause 0 means allowed
  task automatic acc_chk(string req, logic [33:0] a, logic [1:0] kind, logic priv,
                         logic [3:0] exp_cause);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_type = kind; acc_priv = priv;
    @(negedge clk);
    acc_valid = 1'b0;
    expect32(req, {26'd0, chk_valid, chk_fault, chk_cause},
             {26'd0, 1'b1, exp_cause != 4'd0, exp_cause});
  endtask

  task automatic t_reset;
    expect32("R12 chk_valid", {31'd0, chk_valid}, 32'd0);
    csr_chk("R12 cfg0", 12'h3A0, 32'h0);
    csr_chk("R12 addr0", 12'h3B0, 32'h0);
  endtask

  task automatic t_layout;
    csr_wr(12'h3B3, 32'h12345678);
    csr_chk("R1 addr3 readback", 12'h3B3, 32'h12345678);
    csr_wr(12'h3A1, 32'h0B0A0908);
    csr_chk("R1 cfg1 packing", 12'h3A1, 32'h0B0A0908);
    csr_wr(12'h3A1, 32'h0);
    csr_chk("R1 cfg1 cleared", 12'h3A1, 32'h0);
  endtask

  task automatic t_unimpl;
    csr_wr(12'h3B8, 32'hFFFFFFFF);
    csr_chk("R2 addr8 zero", 12'h3B8, 32'h0);
    csr_wr(12'h3A2, 32'hFFFFFFFF);
    csr_chk("R2 cfg2 zero", 12'h3A2, 32'h0);
  endtask

  task automatic t_regions;
    csr_wr(12'h3B0, 32'h40);      // NA4 at 0x100
    csr_wr(12'h3B1, 32'h80);      // TOR 0x100..0x1FF
    csr_wr(12'h3B2, 32'h41F);     // NAPOT 0x1000..0x10FF
    csr_wr(12'h3B3, 32'h800);     // off region at 0x2000
    csr_wr(12'h3A0, 32'h071C0B11);
    acc_chk("R6 NA4 load allowed", 34'h100, 2'd1, 1'b0, 4'd0);
    acc_chk("R8 NA4 wins over TOR store", 34'h100, 2'd2, 1'b0, 4'd7);
    acc_chk("R5 TOR store inside", 34'h104, 2'd2, 1'b0, 4'd0);
    acc_chk("R5 TOR top word", 34'h1FC, 2'd1, 1'b0, 4'd0);
    acc_chk("R5 TOR upper bound excluded", 34'h200, 2'd1, 1'b0, 4'd5);
    acc_chk("R10 below regions denied", 34'h0FC, 2'd1, 1'b0, 4'd5);
    acc_chk("R7 NAPOT fetch last word", 34'h10FC, 2'd0, 1'b0, 4'd0);
    acc_chk("R7 NAPOT first byte fetch", 34'h1000, 2'd0, 1'b0, 4'd0);
    acc_chk("R11 fetch past NAPOT cause 1", 34'h1100, 2'd0, 1'b0, 4'd1);
    acc_chk("R11 NAPOT load no R cause 5", 34'h1000, 2'd1, 1'b0, 4'd5);
    acc_chk("R11 NAPOT store no W cause 7", 34'h1000, 2'd2, 1'b0, 4'd7);
    acc_chk("R4 off region never matches", 34'h2000, 2'd1, 1'b0, 4'd5);
    acc_chk("R9 machine ignores unlocked perms", 34'h1000, 2'd1, 1'b1, 4'd0);
    acc_chk("R9 machine no match allowed", 34'h5000, 2'd2, 1'b1, 4'd0);
    acc_chk("R10 user match grants", 34'h180, 2'd1, 1'b0, 4'd0);
  endtask

  task automatic t_lock;
    csr_wr(12'h3B4, 32'hC00);      // NA4 at 0x3000
    csr_wr(12'h3A1, 32'h00000090); // locked NA4, no permissions
    acc_chk("R9 locked enforced in machine", 34'h3000, 2'd1, 1'b1, 4'd5);
    acc_chk("R9 machine outside locked", 34'h3004, 2'd1, 1'b1, 4'd0);
    csr_wr(12'h3B4, 32'h0);
    csr_chk("R3 locked addr unchanged", 12'h3B4, 32'hC00);
    csr_wr(12'h3A1, 32'h00000F00);
    csr_chk("R3 locked byte kept, neighbour written", 12'h3A1, 32'h00000F90);
    acc_chk("R3 lock still enforced", 34'h3000, 2'd0, 1'b1, 4'd1);
  endtask

  initial begin
    rst_n = 1'b0; csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
    acc_valid = 1'b0; acc_addr = '0; acc_type = '0; acc_priv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_layout();
    t_unimpl();
    t_regions();
    t_lock();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule